// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive byte stream of an Ethernet MAC, just before the buffering that writes frames to memory. It watches the first six bytes of each frame, which hold the destination address, and gives a single accept or reject verdict per frame. The verdict comes from four sources: the station's own address, the all-ones broadcast address, a 64-bit multicast hash table, and a promiscuous override. A global receive enable can veto everything.

The same stream also passes through a length extender. Any frame shorter than the minimum length of 60 bytes is extended with zero bytes, and the frame-end marker moves to the final byte added. The extender only uses idle cycles. The upstream source must leave at least as many idle cycles after a short frame as there are bytes to add. The address filter looks at the extended stream, so a frame that ends before its sixth byte is judged with zero bytes in the missing address positions.

Top module: `rx_addr_filter`

## Requirements
- R1: While `cfg_rx_en` is low in the cycle the sixth stream byte arrives, the verdict is reject, whatever the address.
- R2: While `cfg_rx_en` and `cfg_promisc` are both high, the verdict is accept for any address.
- R3: A frame whose six destination bytes equal the station address is accepted. `sta_word0` holds bytes 0 and 1, `sta_word1` holds bytes 2 and 3, and `sta_word2` holds bytes 4 and 5. In each word the earlier byte is in bits 15:8.
- R4: A destination of six 0xFF bytes is accepted.
- R5: When `cfg_hash_en` is high, an address that matches neither the station nor broadcast is looked up in the hash table, using a 6-bit index. The index is bits 31:26 of a reflected CRC-32 taken over the six destination bytes. The CRC uses polynomial 0xEDB88320, starts from all ones, processes each byte LSB first, and has no final inversion. Index bits 5:4 pick `hash_word0`..`hash_word3`, and index bits 3:0 pick the bit inside that word. The frame is accepted if that bit is 1.
- R6: An address that matches neither the station address nor broadcast is rejected when hashing is disabled, or when its hash bit is 0.
- R7: `dec_valid` pulses for exactly one cycle per frame. The pulse comes in the cycle after the sixth byte of the output stream.
- R8: A frame shorter than 60 bytes leaves the block as 60 bytes. The original bytes come first, then zero bytes, and `out_last` is set on byte 60. A frame of 60 bytes or more passes through unchanged, with `out_last` on its own final byte.
- R9: After reset, `out_valid` and `dec_valid` stay low until a frame is presented.
- R10: For a frame of fewer than six bytes, the address bytes it does not supply are taken as zero from the extension.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_hash_en | input | 1 | Allow multicast hash lookup |
| sta_word0 | input | 16 | Station address bytes 0 (15:8) and 1 (7:0) |
| sta_word1 | input | 16 | Station address bytes 2 and 3 |
| sta_word2 | input | 16 | Station address bytes 4 and 5 |
| hash_word0 | input | 16 | Hash bits for index 0..15 |
| hash_word1 | input | 16 | Hash bits for index 16..31 |
| hash_word2 | input | 16 | Hash bits for index 32..47 |
| hash_word3 | input | 16 | Hash bits for index 48..63 |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_last | input | 1 | Input byte is the last of a frame |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_last | output | 1 | Output byte is the last of the extended frame |
| out_data | output | 8 | Output byte (zero for added bytes) |
| dec_valid | output | 1 | Verdict strobe |
| dec_accept | output | 1 | Verdict: 1 accept, 0 reject |

## Verification
On every cycle, the assertions check these properties:
- the verdict strobe never lasts longer than one cycle, and only follows a stream byte;
- a disabled receiver never accepts and a promiscuous receiver always accepts;
- an extended frame never ends before its 60th byte;
- once extension has started, it continues without a gap.

The rest can only be shown by the bench's directed frames:
- the address comparison itself, including the byte order inside the station words;
- the CRC-derived hash index and the word and bit it selects;
- the priority between the sources;
- the zero content of the added bytes;
- the handling of frames shorter than the address.

// File: rtl/rxaf_pkg.sv
// Shared constants, verdict type and the byte-wide reflected CRC-32 step
// used by the receive destination address filter.
package rxaf_pkg;

    localparam logic [31:0] CRC_POLY = 32'hEDB88320;
    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

    // Which source produced the verdict, highest priority first.
    typedef enum logic [2:0] {
        V_NONE    = 3'd0,
        V_PROMISC = 3'd1,
        V_STATION = 3'd2,
        V_BCAST   = 3'd3,
        V_HASH    = 3'd4
    } verdict_e;

    // Fold one byte into a reflected CRC-32, least significant bit first.
    function automatic logic [31:0] crc32_byte(input logic [31:0] crc_in,
                                               input logic [7:0]  data);
        logic [31:0] c;
        c = crc_in ^ {24'd0, data};
        for (int b = 0; b < 8; b++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/rxaf_pad_extend.sv
// Frame length extender.
// Passes input bytes straight through. When a frame ends before MIN_LEN
// bytes, it emits zero bytes on the following cycles until MIN_LEN bytes
// have been sent, and moves the end marker to the last added byte.
// Assumes: the source stays idle while added bytes are being emitted, and
// every frame starts with in_sof.
module rxaf_pad_extend #(
    parameter int DATA_W  = 8,
    parameter int MIN_LEN = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_last,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_sof,
    output logic              out_last,
    output logic [DATA_W-1:0] out_data
);
    localparam int CW = $clog2(MIN_LEN + 1);
    localparam logic [CW-1:0] LEN_CAP  = CW'(MIN_LEN);
    localparam logic [CW-1:0] LAST_POS = CW'(MIN_LEN - 1);

    logic [CW-1:0] cnt_q;
    logic          pad_q;
    logic [CW-1:0] pos;
    logic          short_end;
    logic          pad_done;

    // Position of the byte on the stream this cycle.
    always_comb pos = (in_valid && in_sof) ? '0 : cnt_q;

    // Detect a frame end that needs extension and the final added byte.
    always_comb begin
        short_end = in_valid && in_last && (pos < LAST_POS);
        pad_done  = pad_q && !in_valid && (cnt_q == LAST_POS);
    end

    // Merge live and added bytes onto the output stream.
    always_comb begin
        out_valid = in_valid || pad_q;
        out_sof   = in_valid && in_sof;
        out_data  = in_valid ? in_data : '0;
        out_last  = (in_valid && in_last && !short_end) || pad_done;
    end

    // Count emitted bytes (saturating) and hold the extension state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= LEN_CAP;
            pad_q <= 1'b0;
        end else begin
            if (out_valid) begin
                cnt_q <= (pos >= LEN_CAP) ? LEN_CAP : pos + 1'b1;
            end
            if (short_end) begin
                pad_q <= 1'b1;
            end else if (pad_done) begin
                pad_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rxaf_addr_capture.sv
// Destination address capture and hash index generator.
// Collects the first ADDR_BYTES bytes of every frame and runs the
// reflected CRC-32 over them one byte per cycle. In the cycle the final
// address byte is on the stream, it presents the whole address and the
// hash index combinationally, together with a done flag.
// Assumes: the stream it watches has no gaps inside the address bytes
// that would reorder them, and each frame starts with byte_sof.
module rxaf_addr_capture
    import rxaf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HIDX_W     = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    byte_valid,
    input  logic                    byte_sof,
    input  logic [7:0]              byte_data,
    output logic                    cap_done,
    output logic [ADDR_BYTES*8-1:0] cap_addr,
    output logic [HIDX_W-1:0]       cap_hidx
);
    localparam int IW = $clog2(ADDR_BYTES + 1);
    localparam logic [IW-1:0] IDX_IDLE = IW'(ADDR_BYTES);
    localparam logic [IW-1:0] IDX_LAST = IW'(ADDR_BYTES - 1);

    logic [IW-1:0] idx_q;
    logic [IW-1:0] pos;
    logic [7:0]    addr_q [ADDR_BYTES];
    logic [31:0]   crc_q;
    logic [31:0]   crc_now;
    logic          in_addr;

    // Byte position within the current frame's address field.
    always_comb begin
        pos     = (byte_valid && byte_sof) ? '0 : idx_q;
        in_addr = byte_valid && (pos < IDX_IDLE);
    end

    // CRC including the byte present this cycle.
    always_comb crc_now = crc32_byte((pos == '0) ? CRC_INIT : crc_q, byte_data);

    // Flag the final address byte and expose the hash index.
    always_comb begin
        cap_done = byte_valid && (pos == IDX_LAST);
        cap_hidx = crc_now[31 -: HIDX_W];
    end

    // Present the full address: earlier bytes from storage, last byte live.
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
        if (g == ADDR_BYTES - 1) begin : g_live
            assign cap_addr[(ADDR_BYTES-g)*8-1 -: 8] = byte_data;
        end else begin : g_held
            assign cap_addr[(ADDR_BYTES-g)*8-1 -: 8] = addr_q[g];
        end
    end

    // Store address bytes, advance the position and the running CRC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= IDX_IDLE;
            crc_q <= CRC_INIT;
            for (int i = 0; i < ADDR_BYTES; i++) begin
                addr_q[i] <= '0;
            end
        end else if (in_addr) begin
            addr_q[pos] <= byte_data;
            crc_q       <= crc_now;
            idx_q       <= pos + 1'b1;
        end
    end

endmodule

// File: rtl/rxaf_decide.sv
// Verdict logic.
// Combines promiscuous mode, station address match, broadcast detection
// and the hash table lookup in fixed priority. Registers a one-cycle strobe
// with the accept bit in the cycle after the final address byte.
// Assumes: configuration is stable around the final address byte.
module rxaf_decide
    import rxaf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 64,
    parameter int HIDX_W     = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_rx_en,
    input  logic                    cfg_promisc,
    input  logic                    cfg_hash_en,
    input  logic [ADDR_BYTES*8-1:0] sta_addr,
    input  logic [HASH_BITS-1:0]    hash_tbl,
    input  logic                    cap_done,
    input  logic [ADDR_BYTES*8-1:0] cap_addr,
    input  logic [HIDX_W-1:0]       cap_hidx,
    output logic                    dec_valid,
    output logic                    dec_accept
);
    verdict_e verdict;
    logic     sta_hit;
    logic     bcast_hit;
    logic     hash_hit;
    logic     accept;

    // Individual match sources.
    always_comb begin
        sta_hit   = (cap_addr == sta_addr);
        bcast_hit = &cap_addr;
        hash_hit  = cfg_hash_en && hash_tbl[cap_hidx];
    end

    // Priority selection of the verdict source.
    always_comb begin
        if (cfg_promisc)      verdict = V_PROMISC;
        else if (sta_hit)     verdict = V_STATION;
        else if (bcast_hit)   verdict = V_BCAST;
        else if (hash_hit)    verdict = V_HASH;
        else                  verdict = V_NONE;
        accept = cfg_rx_en && (verdict != V_NONE);
    end

    // Register the verdict strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
        end else begin
            dec_valid  <= cap_done;
            dec_accept <= cap_done && accept;
        end
    end

endmodule

// File: rtl/rx_addr_filter.sv
// Receive destination address filter, top level.
// Extends short frames to the minimum length and judges each frame's
// destination address on the extended stream. Station and hash words are
// packed so that the earlier address byte is the high byte of each word.
// Assumes: see rxaf_pad_extend for the idle-cycle rule after short frames.
module rx_addr_filter #(
    parameter int MIN_LEN     = 60,
    parameter int ADDR_BYTES  = 6,
    parameter int WORD_W      = 16,
    parameter int HASH_WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_rx_en,
    input  logic              cfg_promisc,
    input  logic              cfg_hash_en,
    input  logic [WORD_W-1:0] sta_word0,
    input  logic [WORD_W-1:0] sta_word1,
    input  logic [WORD_W-1:0] sta_word2,
    input  logic [WORD_W-1:0] hash_word0,
    input  logic [WORD_W-1:0] hash_word1,
    input  logic [WORD_W-1:0] hash_word2,
    input  logic [WORD_W-1:0] hash_word3,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_last,
    input  logic [7:0]        in_data,
    output logic              out_valid,
    output logic              out_last,
    output logic [7:0]        out_data,
    output logic              dec_valid,
    output logic              dec_accept
);
    localparam int HASH_BITS = HASH_WORDS * WORD_W;
    localparam int HIDX_W    = $clog2(HASH_BITS);

    logic                    s_sof;
    logic                    cap_done;
    logic [ADDR_BYTES*8-1:0] cap_addr;
    logic [HIDX_W-1:0]       cap_hidx;
    logic [ADDR_BYTES*8-1:0] sta_addr;
    logic [HASH_BITS-1:0]    hash_tbl;

    // Station words in address order; hash words with word 0 lowest.
    always_comb begin
        sta_addr = {sta_word0, sta_word1, sta_word2};
        hash_tbl = {hash_word3, hash_word2, hash_word1, hash_word0};
    end

    rxaf_pad_extend #(
        .DATA_W  (8),
        .MIN_LEN (MIN_LEN)
    ) u_pad (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_last   (in_last),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_sof   (s_sof),
        .out_last  (out_last),
        .out_data  (out_data)
    );

    rxaf_addr_capture #(
        .ADDR_BYTES (ADDR_BYTES),
        .HIDX_W     (HIDX_W)
    ) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (out_valid),
        .byte_sof   (s_sof),
        .byte_data  (out_data),
        .cap_done   (cap_done),
        .cap_addr   (cap_addr),
        .cap_hidx   (cap_hidx)
    );

    rxaf_decide #(
        .ADDR_BYTES (ADDR_BYTES),
        .HASH_BITS  (HASH_BITS),
        .HIDX_W     (HIDX_W)
    ) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_rx_en   (cfg_rx_en),
        .cfg_promisc (cfg_promisc),
        .cfg_hash_en (cfg_hash_en),
        .sta_addr    (sta_addr),
        .hash_tbl    (hash_tbl),
        .cap_done    (cap_done),
        .cap_addr    (cap_addr),
        .cap_hidx    (cap_hidx),
        .dec_valid   (dec_valid),
        .dec_accept  (dec_accept)
    );

endmodule

// File: rtl/rx_addr_filter_chk.sv
// Port-level checker for rx_addr_filter, attached by bind.
// Tracks the output byte count itself to check the minimum length.
module rx_addr_filter_chk #(
    parameter int MIN_LEN = 60
) (
    input logic clk,
    input logic rst_n,
    input logic cfg_rx_en,
    input logic cfg_promisc,
    input logic in_valid,
    input logic in_sof,
    input logic out_valid,
    input logic out_last,
    input logic dec_valid,
    input logic dec_accept
);
    localparam int CW = $clog2(MIN_LEN + 1);
    localparam logic [CW-1:0] CAP = CW'(MIN_LEN);

    logic [CW-1:0] seen_q;
    logic [CW-1:0] seen_pos;

    // Position of the current output byte within its frame.
    always_comb seen_pos = (in_valid && in_sof) ? '0 : seen_q;

    // Count output bytes per frame, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= CAP;
        end else if (out_valid) begin
            seen_q <= (seen_pos >= CAP) ? CAP : seen_pos + 1'b1;
        end
    end

    // R7
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    // R7
    strobe_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(out_valid));

    // R1
    rx_off_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !$past(cfg_rx_en)) |-> !dec_accept);

    // R2
    promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && $past(cfg_rx_en && cfg_promisc)) |-> dec_accept);

    // R8
    min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> (seen_pos >= CW'(MIN_LEN - 1)));

    // R8
    pad_continuous_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !in_valid && !out_last) |=> out_valid);

endmodule

bind rx_addr_filter rx_addr_filter_chk #(.MIN_LEN(MIN_LEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_rx_en   (cfg_rx_en),
    .cfg_promisc (cfg_promisc),
    .in_valid    (in_valid),
    .in_sof      (in_sof),
    .out_valid   (out_valid),
    .out_last    (out_last),
    .dec_valid   (dec_valid),
    .dec_accept  (dec_accept)
);

// File: tb/rx_addr_filter_tb.sv
// Directed bench for rx_addr_filter: one task per scenario.
module rx_addr_filter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_rx_en = 1'b0, cfg_promisc = 1'b0, cfg_hash_en = 1'b0;
    logic [15:0] sta_word0 = '0, sta_word1 = '0, sta_word2 = '0;
    logic [15:0] hash_word0 = '0, hash_word1 = '0, hash_word2 = '0, hash_word3 = '0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_last = 1'b0;
    logic [7:0]  in_data = '0;
    logic        out_valid, out_last, dec_valid, dec_accept;
    logic [7:0]  out_data;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // Monitor state
    int         ob_cnt, last_idx, dec_cnt, dec_cyc, six_cyc;
    logic       dec_acc;
    logic [7:0] got_b [128];
    logic [7:0] exp_b [128];

    rx_addr_filter u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_rx_en(cfg_rx_en), .cfg_promisc(cfg_promisc), .cfg_hash_en(cfg_hash_en),
        .sta_word0(sta_word0), .sta_word1(sta_word1), .sta_word2(sta_word2),
        .hash_word0(hash_word0), .hash_word1(hash_word1),
        .hash_word2(hash_word2), .hash_word3(hash_word3),
        .in_valid(in_valid), .in_sof(in_sof), .in_last(in_last), .in_data(in_data),
        .out_valid(out_valid), .out_last(out_last), .out_data(out_data),
        .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Record the output stream and verdict away from the active edge.
    always @(negedge clk) begin
        if (out_valid) begin
            if (ob_cnt < 128) got_b[ob_cnt] = out_data;
            if (ob_cnt == 5) six_cyc = cyc;
            if (out_last) last_idx = ob_cnt;
            ob_cnt = ob_cnt + 1;
        end
        if (dec_valid) begin
            dec_cnt = dec_cnt + 1;
            dec_acc = dec_accept;
            dec_cyc = cyc;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference hash index: reflected CRC-32, bit by bit, no final inversion.
    function automatic int ref_hidx(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb = c[0] ^ a[47 - 8*i - 7 + b];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return int'(c[31:26]);
    endfunction

    // Drive one frame, then idle long enough for extension and verdict.
    task automatic send_frame(input int len, input logic [47:0] dst);
        ob_cnt = 0; last_idx = -1; dec_cnt = 0; dec_cyc = -1; six_cyc = -1; dec_acc = 1'b0;
        for (int i = 0; i < 128; i++) exp_b[i] = 8'h00;
        for (int i = 0; i < len; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_last  = (i == len - 1);
            in_data  = (i < 6) ? dst[47 - 8*i -: 8] : 8'(8'h30 + i);
            exp_b[i] = in_data;
        end
        @(posedge clk); #1;
        in_valid = 1'b0; in_sof = 1'b0; in_last = 1'b0; in_data = '0;
        repeat (70) @(posedge clk);
        #1;
    endtask

    // Common checks on the stream and verdict of the last frame.
    task automatic check_frame(input int len, input bit exp_acc, input string tag);
        int olen = (len < 60) ? 60 : len;
        int bad = 0;
        chk(dec_cnt == 1, "R7 one strobe", dec_cnt, 1);
        chk(dec_cyc == six_cyc + 1, "R7 strobe timing", dec_cyc, six_cyc + 1);
        chk(dec_acc == exp_acc, tag, int'(dec_acc), int'(exp_acc));
        chk(ob_cnt == olen, "R8 output length", ob_cnt, olen);
        chk(last_idx == olen - 1, "R8 end marker position", last_idx, olen - 1);
        for (int i = 0; i < olen && i < 128; i++) if (got_b[i] !== exp_b[i]) bad++;
        chk(bad == 0, "R8 byte content", bad, 0);
    endtask

    task automatic set_station(input logic [47:0] a);
        sta_word0 = a[47:32]; sta_word1 = a[31:16]; sta_word2 = a[15:0];
    endtask

    task automatic set_hash_bit(input int idx);
        hash_word0 = '0; hash_word1 = '0; hash_word2 = '0; hash_word3 = '0;
        case (idx / 16)
            0: hash_word0[idx % 16] = 1'b1;
            1: hash_word1[idx % 16] = 1'b1;
            2: hash_word2[idx % 16] = 1'b1;
            default: hash_word3[idx % 16] = 1'b1;
        endcase
    endtask

    task automatic t_reset;
        chk(out_valid == 1'b0, "R9 out_valid after reset", int'(out_valid), 0);
        chk(dec_valid == 1'b0, "R9 dec_valid after reset", int'(dec_valid), 0);
    endtask

    task automatic t_station;
        cfg_rx_en = 1; cfg_promisc = 0; cfg_hash_en = 0;
        set_station(48'h0A1B_2C3D_4E5F);
        send_frame(64, 48'h0A1B_2C3D_4E5F);
        check_frame(64, 1'b1, "R3 station match");
        // Byte order within a word: swapped bytes must not match.
        send_frame(64, 48'h1B0A_2C3D_4E5F);
        check_frame(64, 1'b0, "R3 swapped byte rejected");
    endtask

    task automatic t_bcast;
        cfg_rx_en = 1; cfg_promisc = 0; cfg_hash_en = 0;
        send_frame(20, 48'hFFFF_FFFF_FFFF);
        check_frame(20, 1'b1, "R4 broadcast");
    endtask

    task automatic t_hash;
        logic [47:0] mc = 48'h0100_5E00_0001;
        int idx = ref_hidx(mc);
        cfg_rx_en = 1; cfg_promisc = 0; cfg_hash_en = 1;
        set_hash_bit(idx);
        send_frame(61, mc);
        check_frame(61, 1'b1, "R5 hash hit");
        // Same bit position in another word must not hit.
        set_hash_bit(((idx / 16 + 1) % 4) * 16 + idx % 16);
        send_frame(61, mc);
        check_frame(61, 1'b0, "R6 hash wrong word");
        // Bit set but hashing off.
        set_hash_bit(idx);
        cfg_hash_en = 0;
        send_frame(61, mc);
        check_frame(61, 1'b0, "R6 hash disabled");
    endtask

    task automatic t_promisc;
        cfg_rx_en = 1; cfg_promisc = 1; cfg_hash_en = 0;
        send_frame(40, 48'h1234_5678_9ABC);
        check_frame(40, 1'b1, "R2 promiscuous");
        cfg_promisc = 0;
        send_frame(40, 48'h1234_5678_9ABC);
        check_frame(40, 1'b0, "R6 unknown rejected");
    endtask

    task automatic t_rx_off;
        cfg_rx_en = 0; cfg_promisc = 1; cfg_hash_en = 1;
        set_station(48'h0A1B_2C3D_4E5F);
        send_frame(64, 48'h0A1B_2C3D_4E5F);
        check_frame(64, 1'b0, "R1 receive disabled");
        cfg_promisc = 0;
    endtask

    task automatic t_tiny;
        cfg_rx_en = 1; cfg_promisc = 0; cfg_hash_en = 0;
        set_station(48'hAABB_CC00_0000);
        send_frame(3, 48'hAABB_CC11_2233);
        check_frame(3, 1'b1, "R10 short address zero filled");
        send_frame(60, 48'hAABB_CC11_2233);
        check_frame(60, 1'b0, "R10 full address differs");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        ob_cnt = 0; last_idx = -1; dec_cnt = 0; dec_cyc = -1; six_cyc = -1; dec_acc = 1'b0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_station();
        t_bcast();
        t_hash();
        t_promisc();
        t_rx_off();
        t_tiny();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule